// File: doc/BRIEF.md
# Sticky Masked Interrupt Status Register

This block collects eight event conditions from a phone-line interface controller into one 8-bit sticky flag register. Once a flag is set, it stays set until host software clears it by writing a 0 to that bit position. A mask register and a global enable decide which flags reach a single registered, active-high interrupt pin. The host sees the block through a small write/read port with four word addresses: flags, mask, control and status.

The ring flag is derived from a raw ring-pulse input. That input is synchronized and then edge-detected. The flag is always set on the pulse's leading edge. It is also set on the trailing edge when a control bit selects both-edge mode. The frame flag follows a level condition and sets while frame lock is lost. The loop-current overload flag sets whenever the loop-current measurement field reads all ones. The receive-overload flag has a linked status bit at the status address. Both are set together, and both are cleared by the same flag write.

Top module: `line_irq_status`

## Requirements
- R1: After reset the flag, mask, control and status registers read 0 and `irq` is low.
- R2: Flag bit positions from bit 7 to bit 0 are: ring, receive overload, frame lost, billing tone, power dropout, loop-current overload, loop-current change, line polarity. An event present before a clock edge sets its flag at that edge.
- R3: A set flag stays set in every later cycle until a write to address 0 carries 0 in that bit. Such a write clears the flag at the write's clock edge.
- R4: Writing 1 to a flag bit at address 0 leaves that bit unchanged, so software can never set a flag.
- R5: When a set event and a clearing write hit the same bit in the same cycle, the bit ends up set.
- R6: Address 3 bit 0 is a receive-overload status bit. It sets with flag bit 6 and is cleared by the same write that clears flag bit 6. It always equals flag bit 6.
- R7: Ring edges are detected after a SYNC_STAGES-flop synchronizer (2 by default). A rising ring input sets flag bit 7 at the third clock edge after it changes. A falling ring input does the same only when control bit 1 (address 2) is 1.
- R8: While `frame_lost` is high, flag bit 5 is set again every cycle, so a clearing write does not leave it at 0.
- R9: Flag bit 2 sets only when every bit of `loop_meas` is 1. Any other value leaves it untouched.
- R10: `irq` is registered. It is high one cycle after a cycle in which control bit 0 (address 2) is 1 and some flag is set with its mask bit (address 1) at 1. Otherwise it is low.
- R11: Address 1 reads back the 8-bit mask and address 2 reads back the two control bits. Address 3 is read-only.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ring_in | input | 1 | Raw ring pulse, asynchronous |
| ev_rx_ovl | input | 1 | Receive overload event |
| frame_lost | input | 1 | Frame lock lost, level |
| ev_billing | input | 1 | Billing tone event |
| ev_dropout | input | 1 | Line-side supply dropout event |
| loop_meas | input | LOOP_W | Loop-current measurement field |
| ev_loop_chg | input | 1 | Loop-current change event |
| ev_polarity | input | 1 | Line polarity reversal event |
| wr_en | input | 1 | Host write strobe |
| addr | input | 2 | Register address: 0 flags, 1 mask, 2 control, 3 status |
| wdata | input | 8 | Host write data |
| rdata | output | 8 | Read data for `addr`, combinational |
| irq | output | 1 | Interrupt request, active high |

## Verification
Direct events and host writes take effect on flags at the clock edge where they are present. The interrupt pin follows one edge later. A ring input change needs three edges to reach flag bit 7: two synchronizer flops and then the flag flop. The bench drives every input on the falling clock edge and samples flags on the next falling edge, and it samples `irq` one falling edge after that. For ring checks it waits exactly three falling edges. `rdata` is combinational, so it is read 1 ns after the address settles, within the same low half-cycle.

// File: rtl/line_irq_status.sv
module line_irq_status #(
  parameter int LOOP_W      = 6,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ring_in,
  input  logic              ev_rx_ovl,
  input  logic              frame_lost,
  input  logic              ev_billing,
  input  logic              ev_dropout,
  input  logic [LOOP_W-1:0] loop_meas,
  input  logic              ev_loop_chg,
  input  logic              ev_polarity,
  input  logic              wr_en,
  input  logic [1:0]        addr,
  input  logic [7:0]        wdata,
  output logic [7:0]        rdata,
  output logic              irq
);

  localparam logic [1:0] A_FLAG = 2'd0;
  localparam logic [1:0] A_MASK = 2'd1;
  localparam logic [1:0] A_CTRL = 2'd2;
  localparam logic [1:0] A_STAT = 2'd3;

  logic [SYNC_STAGES-1:0] ring_sync;
  logic                   ring_prev;
  logic [7:0]             flags, mask;
  logic [1:0]             ctrl;
  logic                   rx_stat, irq_q;

  wire ring_now  = ring_sync[SYNC_STAGES-1];
  wire both_edge = ctrl[1];
  wire gie       = ctrl[0];
  wire ring_hit  = (ring_now & ~ring_prev) | (both_edge & ~ring_now & ring_prev);
  wire wr_flags  = wr_en && (addr == A_FLAG);
  wire [7:0] keep    = wr_flags ? wdata : 8'hFF;
  wire [7:0] set_vec = {ring_hit, ev_rx_ovl, frame_lost, ev_billing,
                        ev_dropout, &loop_meas, ev_loop_chg, ev_polarity};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ring_sync <= '0;
      ring_prev <= 1'b0;
    end else begin
      ring_sync <= {ring_sync[SYNC_STAGES-2:0], ring_in};
      ring_prev <= ring_now;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      flags   <= '0;
      rx_stat <= 1'b0;
    end else begin
      flags   <= (flags & keep) | set_vec;
      rx_stat <= (rx_stat & keep[6]) | ev_rx_ovl;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mask <= '0;
      ctrl <= '0;
    end else if (wr_en) begin
      if (addr == A_MASK) mask <= wdata;
      if (addr == A_CTRL) ctrl <= wdata[1:0];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) irq_q <= 1'b0;
    else        irq_q <= gie & |(flags & mask);
  end

  assign irq = irq_q;

  always_comb begin
    case (addr)
      A_FLAG:  rdata = flags;
      A_MASK:  rdata = mask;
      A_CTRL:  rdata = {6'b0, ctrl};
      A_STAT:  rdata = {7'b0, rx_stat};
      default: rdata = 8'h00;
    endcase
  end

  AST_FLAG_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_flags |=> ((flags & $past(flags)) == $past(flags))); // R3
  AST_NO_SW_SET: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_flags && set_vec == 8'h00) |=> ((flags & ~$past(flags)) == 8'h00)); // R4
  AST_SET_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    ev_billing |=> flags[4]); // R5
  AST_RX_LINK: assert property (@(posedge clk) disable iff (!rst_n)
    rx_stat == flags[6]); // R6
  AST_IRQ_OFF: assert property (@(posedge clk) disable iff (!rst_n)
    !gie |=> !irq); // R10
  AST_IRQ_ON: assert property (@(posedge clk) disable iff (!rst_n)
    (gie && (flags & mask) != 8'h00) |=> irq); // R10
  AST_FALL_GATED: assert property (@(posedge clk) disable iff (!rst_n)
    (!both_edge && !ring_now && !flags[7] && !(ring_sync[SYNC_STAGES-2] && !ring_now)) |=> !flags[7]); // R7

endmodule

// File: tb/test_line_irq_status.sv
module test_line_irq_status;
  localparam int LOOP_W = 6;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic ring_in = 0, ev_rx_ovl = 0, frame_lost = 0, ev_billing = 0;
  logic ev_dropout = 0, ev_loop_chg = 0, ev_polarity = 0, wr_en = 0;
  logic [LOOP_W-1:0] loop_meas = '0;
  logic [1:0] addr = 2'd0;
  logic [7:0] wdata = 8'h00;
  logic [7:0] rdata;
  logic irq;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  line_irq_status #(.LOOP_W(LOOP_W), .SYNC_STAGES(2)) i_line_irq_status (
    .clk(clk), .rst_n(rst_n), .ring_in(ring_in), .ev_rx_ovl(ev_rx_ovl),
    .frame_lost(frame_lost), .ev_billing(ev_billing), .ev_dropout(ev_dropout),
    .loop_meas(loop_meas), .ev_loop_chg(ev_loop_chg), .ev_polarity(ev_polarity),
    .wr_en(wr_en), .addr(addr), .wdata(wdata), .rdata(rdata), .irq(irq));

  always #5 clk = ~clk;

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%02h expected=%02h", req, act, exp);
    end
  endtask

  task automatic rd(input logic [1:0] a, output logic [7:0] v);
    addr = a;
    #1 v = rdata;
  endtask

  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    wr_en = 1; addr = a; wdata = d;
    @(negedge clk);
    wr_en = 0;
  endtask

  task automatic set_event(input int b, input logic v);
    case (b)
      0: ev_polarity = v;
      1: ev_loop_chg = v;
      2: loop_meas = v ? '1 : '0;
      3: ev_dropout = v;
      4: ev_billing = v;
      5: frame_lost = v;
      6: ev_rx_ovl = v;
      default: ;
    endcase
  endtask

  initial begin
    #2_000_000;
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog expired");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    logic [7:0] v;
    repeat (2) @(negedge clk);
    for (int a = 0; a < 4; a++) begin
      rd(a[1:0], v); chk("R1 reset reg", v, 8'h00);
    end
    chk("R1 reset irq", {7'b0, irq}, 8'h00);
    rst_n = 1;
    @(negedge clk);

    wr(2'd1, 8'hA5); rd(2'd1, v); chk("R11 mask readback", v, 8'hA5);
    wr(2'd2, 8'hFF); rd(2'd2, v); chk("R11 ctrl readback", v, 8'h03);
    wr(2'd3, 8'hFF); rd(2'd3, v); chk("R11 status read-only", v, 8'h00);
    wr(2'd2, 8'h00);

    for (int b = 0; b < 7; b++) begin
      for (int g = 0; g < 2; g++) begin
        for (int m = 0; m < 2; m++) begin
          logic [7:0] bitv;
          bitv = 8'h01 << b;
          wr(2'd1, m ? bitv : ~bitv);
          wr(2'd2, {7'b0, g[0]});
          set_event(b, 1'b1);
          @(negedge clk);
          set_event(b, 1'b0);
          rd(2'd0, v); chk("R2 event sets its bit", v, bitv);
          if (b == 6) begin rd(2'd3, v); chk("R6 status set", v, 8'h01); end
          @(negedge clk);
          chk("R10 irq after set", {7'b0, irq}, {7'b0, g[0] & m[0]});
          repeat (3) @(negedge clk);
          rd(2'd0, v); chk("R3 flag holds", v, bitv);
          wr(2'd0, 8'hFF); rd(2'd0, v); chk("R4 write ones inert", v, bitv);
          wr(2'd0, ~bitv); rd(2'd0, v); chk("R3 write zero clears", v, 8'h00);
          if (b == 6) begin rd(2'd3, v); chk("R6 status cleared", v, 8'h00); end
          @(negedge clk);
          chk("R10 irq after clear", {7'b0, irq}, 8'h00);
        end
      end
    end

    ev_billing = 1;
    wr(2'd0, 8'h00);
    ev_billing = 0;
    rd(2'd0, v); chk("R5 set wins over clear", v, 8'h10);
    wr(2'd0, 8'h00);

    frame_lost = 1;
    @(negedge clk);
    wr(2'd0, 8'h00); rd(2'd0, v); chk("R8 frame stays set while lost", v, 8'h20);
    frame_lost = 0;
    wr(2'd0, 8'h00); rd(2'd0, v); chk("R8 frame clears after lock", v, 8'h00);

    for (int k = 0; k < (1 << LOOP_W); k++) begin
      loop_meas = k[LOOP_W-1:0];
      @(negedge clk);
      rd(2'd0, v);
      chk("R9 loop overload only at all ones", v, (k == (1 << LOOP_W) - 1) ? 8'h04 : 8'h00);
      wr(2'd0, 8'h00);
    end
    loop_meas = '0;
    wr(2'd0, 8'h00);

    for (int be = 0; be < 2; be++) begin
      wr(2'd2, {6'b0, be[0], 1'b0});
      ring_in = 1;
      repeat (2) @(negedge clk);
      rd(2'd0, v); chk("R7 ring not yet set", v, 8'h00);
      @(negedge clk);
      rd(2'd0, v); chk("R7 ring rise sets", v, 8'h80);
      wr(2'd0, 8'h00);
      ring_in = 0;
      repeat (3) @(negedge clk);
      rd(2'd0, v); chk("R7 ring fall per select", v, be ? 8'h80 : 8'h00);
      wr(2'd0, 8'h00);
    end

    wr(2'd1, 8'h80); wr(2'd2, 8'h01);
    ring_in = 1;
    repeat (4) @(negedge clk);
    chk("R10 irq from ring", {7'b0, irq}, 8'h01);
    ring_in = 0;
    wr(2'd2, 8'h00);
    @(negedge clk);
    chk("R10 irq off when disabled", {7'b0, irq}, 8'h00);

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule